// File: doc/BRIEF.md
# Word-to-Bit Serializer with Looped Divided Clock

This block turns a stream of 32-bit parallel words into one serial bit stream running 32 times faster. It runs from an ideal bit-rate clock, divides that clock by 32 and drives the result out as a word-rate clock. The upstream logic launches its data from that divided clock. A copy of the same clock comes back to this block after an unknown but bounded board and logic delay, and the block captures each parallel word on the rising edge of that returned clock.

The captured word is then moved into the bit-clock domain. A hold register samples it at a fixed divider count, chosen so that the sample falls in the middle of the window where the captured word is stable. At the last count of each word period the held word is loaded into a shift register. The serial output register is updated on the falling edge of the bit clock. Bit 0 of every word goes out first and bit 31 last, and consecutive words follow each other with no gap.

Top module: `ser32_mux`

## Requirements
- R1: `div_clk_out` is a square wave with a period of 32 bit-clock cycles. It is high for 16 cycles and low for 16 cycles, and it first rises on the 16th rising bit-clock edge after reset is released.
- R2: While `rst` is high at rising bit-clock edges, the divider count, the hold register and the shift register are cleared. `div_clk_out` and `serial_out` are 0.
- R3: Each word is sent in this order: `par_data[0]` first, then `par_data[1]`, and so on up to `par_data[31]` last. Each bit lasts one bit-clock period.
- R4: Only the value of `par_data` present at a rising edge of `word_clk_in` is sent. Changes to `par_data` at any other time have no effect on the serial stream.
- R5: The captured word is sampled into the hold register when the divider count is `XFER_AT` (default 24). The shift register is loaded at count 31. The stream is correct for any loop delay from `div_clk_out` to `word_clk_in` that is less than `XFER_AT - 15` bit periods (default: 9).
- R6: `serial_out` changes only on falling edges of `bit_clk`.
- R7: Bit 0 of the word captured after a rising edge of `div_clk_out` appears on `serial_out` 16.5 bit periods after that rise, on a falling edge. Until that point after reset, `serial_out` stays 0.
- R8: Words captured on consecutive `word_clk_in` edges are sent back to back, with the same order and no idle bits between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset, bit-clock domain |
| word_clk_in | input | 1 | Returned word-rate clock; its rising edge captures `par_data` |
| par_data | input | WORD_W | Parallel word; bit 0 is sent first |
| div_clk_out | output | 1 | Bit clock divided by WORD_W, 50% duty |
| serial_out | output | 1 | Serial data, updated on falling `bit_clk` |

## Verification
The checker confirms on every cycle that each half period of the divided clock is exactly 16 bit clocks long. It also confirms that the serial output never moves on a rising edge, that the hold register changes only at the transfer count, that the captured word has settled at the transfer point, and that the first bit after each load matches the held word. End-to-end ordering, the latency measured from the divided clock, immunity to data changes between capture edges, and correct operation across several loop delays can only be shown by the bench. It does this by deserializing the output and comparing it with the words it launched.

// File: rtl/ser32_pkg.sv
package ser32_pkg;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_XFER_AT = 24;
endpackage

// File: rtl/ser32_divider.sv
// Free-running word counter on the bit clock; MSB is the divided clock.
module ser32_divider #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned XFER_AT = 24,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic             bit_clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             div_o,
  output logic             xfer_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] XFER_C = CNT_W'(XFER_AT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge bit_clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign div_o  = cnt_q[CNT_W-1];
  assign xfer_o = (cnt_q == XFER_C);
  assign load_o = (cnt_q == LAST_C);
endmodule

// File: rtl/ser32_capture.sv
// Word capture on the returned clock, then a hold stage in the bit domain.
module ser32_capture #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              word_clk,
  input  logic [WORD_W-1:0] par_i,
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              xfer_i,
  output logic [WORD_W-1:0] cap_o,
  output logic [WORD_W-1:0] hold_o
);
  logic [WORD_W-1:0] cap_q;
  logic [WORD_W-1:0] hold_q;

  // Returned-clock domain: no reset, the first capture overwrites it.
  always_ff @(posedge word_clk) cap_q <= par_i;

  // Sampled only at the transfer count, where cap_q is known to be settled.
  always_ff @(posedge bit_clk) begin
    if (rst)         hold_q <= '0;
    else if (xfer_i) hold_q <= cap_q;
  end

  assign cap_o  = cap_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/ser32_shifter.sv
// Shift register loaded once per word; output retimed on the falling edge.
module ser32_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o
);
  logic [WORD_W-1:0] sh_q;
  logic              ser_q;

  always_ff @(posedge bit_clk) begin
    if (rst)         sh_q <= '0;
    else if (load_i) sh_q <= word_i;
    else             sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end

  always_ff @(negedge bit_clk) begin
    if (rst) ser_q <= 1'b0;
    else     ser_q <= sh_q[0];
  end

  assign ser_o = ser_q;
endmodule

// File: rtl/ser32_mux.sv
module ser32_mux #(
  parameter int unsigned WORD_W  = ser32_pkg::DEF_WORD_W,
  parameter int unsigned XFER_AT = ser32_pkg::DEF_XFER_AT,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              word_clk_in,
  input  logic [WORD_W-1:0] par_data,
  output logic              div_clk_out,
  output logic              serial_out
);
  logic [CNT_W-1:0]  cnt_q;
  logic              xfer_s;
  logic              load_s;
  logic [WORD_W-1:0] cap_q;
  logic [WORD_W-1:0] hold_q;

  ser32_divider #(.WORD_W(WORD_W), .XFER_AT(XFER_AT)) u_div (
    .bit_clk(bit_clk), .rst(rst), .cnt_o(cnt_q), .div_o(div_clk_out),
    .xfer_o(xfer_s), .load_o(load_s)
  );

  ser32_capture #(.WORD_W(WORD_W)) u_cap (
    .word_clk(word_clk_in), .par_i(par_data), .bit_clk(bit_clk), .rst(rst),
    .xfer_i(xfer_s), .cap_o(cap_q), .hold_o(hold_q)
  );

  ser32_shifter #(.WORD_W(WORD_W)) u_sh (
    .bit_clk(bit_clk), .rst(rst), .load_i(load_s), .word_i(hold_q),
    .ser_o(serial_out)
  );
endmodule

// File: rtl/ser32_mux_chk.sv
module ser32_mux_chk #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned XFER_AT = 24,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input logic              bit_clk,
  input logic              rst,
  input logic              div_clk_out,
  input logic              serial_out,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [WORD_W-1:0] cap_q,
  input logic [WORD_W-1:0] hold_q
);
  localparam int unsigned     HALF   = WORD_W / 2;
  localparam logic [CNT_W-1:0] XFER_C = CNT_W'(XFER_AT);

  logic       prev_div;
  logic       armed;
  logic [7:0] run;
  logic       ser_pos;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      prev_div <= 1'b0;
      armed    <= 1'b0;
      run      <= '0;
      ser_pos  <= 1'b0;
    end else begin
      prev_div <= div_clk_out;
      ser_pos  <= serial_out;
      if (div_clk_out != prev_div) begin
        run   <= 8'd1;
        armed <= 1'b1;
      end else begin
        run <= run + 8'd1;
      end
    end
  end

  // R1: every half period of the divided clock is HALF bit clocks.
  a_r1_half_period: assert property (@(posedge bit_clk) disable iff (rst)
    (armed && (div_clk_out != prev_div)) |-> (run == 8'(HALF)));

  // R6: serial output unchanged across a rising edge.
  a_r6_change_on_fall: assert property (@(negedge bit_clk) disable iff (rst)
    serial_out == ser_pos);

  // R5: hold register moves only at the transfer count.
  a_r5_hold_only_at_xfer: assert property (@(posedge bit_clk) disable iff (rst)
    ($past(cnt_q) != XFER_C) |-> $stable(hold_q));

  // R5: captured word has settled when it is sampled.
  a_r5_cap_settled: assert property (@(posedge bit_clk) disable iff (rst)
    (cnt_q == XFER_C) |-> $stable(cap_q));

  // R3: first bit after a load is bit 0 of the held word.
  a_r3_first_bit: assert property (@(posedge bit_clk) disable iff (rst)
    (cnt_q == '0) |-> (serial_out == $past(hold_q[0])));
endmodule

bind ser32_mux ser32_mux_chk #(.WORD_W(WORD_W), .XFER_AT(XFER_AT)) u_chk (
  .bit_clk(bit_clk), .rst(rst), .div_clk_out(div_clk_out),
  .serial_out(serial_out), .cnt_q(cnt_q), .cap_q(cap_q), .hold_q(hold_q)
);

// File: tb/ser32_mux_tb.sv
`timescale 1ns/1ps
module ser32_mux_tb;
  localparam int  W      = 32;
  localparam time CLK_P  = 10;
  localparam int  NWORDS = 6;

  logic         bit_clk = 1'b0;
  logic         rst = 1'b1;
  logic         word_clk_in = 1'b0;
  logic [W-1:0] par_data = '0;
  logic         div_clk_out;
  logic         serial_out;

  int           n_checks = 0;
  int           n_fail = 0;
  int           dly = 1;
  logic         glitch = 1'b0;
  logic [W-1:0] words [0:NWORDS+3];
  int           idx = 0;
  logic         done = 1'b0;

  ser32_mux u_dut (
    .bit_clk(bit_clk), .rst(rst), .word_clk_in(word_clk_in),
    .par_data(par_data), .div_clk_out(div_clk_out), .serial_out(serial_out)
  );

  always #(CLK_P/2) bit_clk = ~bit_clk;

  // External loop delay from divided clock back to the capture clock.
  always @(div_clk_out) word_clk_in <= #(dly) div_clk_out;

  // Upstream launch: next word on the falling returned clock.
  always @(negedge word_clk_in) begin
    if (!rst) begin
      idx = idx + 1;
      par_data = words[idx];
    end
  end

  // R4 stimulus: disturb the data between capture edges.
  always @(posedge word_clk_in) begin
    if (glitch) begin
      #3;
      par_data = ~words[idx];
    end
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge bit_clk);
    rst = 1'b1;
    repeat (20) @(negedge bit_clk);
    // R2: outputs held low during reset
    check(serial_out == 1'b0 && div_clk_out == 1'b0, "R2",
          {30'd0, div_clk_out, serial_out}, '0);
    for (int k = 0; k < NWORDS + 4; k++) words[k] = $urandom();
    idx = 0;
    par_data = words[0];
    rst = 1'b0;
  endtask

  task automatic run_stream(input int d, input logic g);
    logic [W-1:0] got;
    dly = d;
    glitch = g;
    do_reset();
    @(posedge div_clk_out);
    repeat (16) @(posedge bit_clk);
    #1;
    // R7: nothing but zeros until the first load reaches the output
    check(serial_out == 1'b0, "R7 pre", {31'd0, serial_out}, '0);
    for (int k = 0; k < NWORDS; k++) begin
      got = '0;
      for (int i = 0; i < W; i++) begin
        @(posedge bit_clk);
        #1;
        got[i] = serial_out;
        if (k == 0 && i == 0)
          // R7: bit 0 of first word 16.5 periods after the divided rise
          check(serial_out == words[0][0], "R7 latency",
                {31'd0, serial_out}, {31'd0, words[0][0]});
      end
      // R3/R8 order and continuity, R5 for this delay, R4 when glitching
      check(got == words[k], g ? "R4 R3 R8" : "R3 R5 R8", got, words[k]);
    end
    glitch = 1'b0;
  endtask

  task automatic check_divider();
    time t_rise, t_fall, t_rise2;
    int  n_edges;
    dly = 1;
    do_reset();
    n_edges = 0;
    while (!div_clk_out) begin
      @(posedge bit_clk);
      #1;
      n_edges++;
    end
    // R1: first rise on the 16th edge after release
    check(n_edges == 16, "R1 first rise", W'(n_edges), W'(16));
    @(posedge div_clk_out); t_rise = $time;
    @(negedge div_clk_out); t_fall = $time;
    @(posedge div_clk_out); t_rise2 = $time;
    check((t_fall - t_rise) == 16 * CLK_P, "R1 high", W'(t_fall - t_rise), W'(16 * CLK_P));
    check((t_rise2 - t_rise) == 32 * CLK_P, "R1 period", W'(t_rise2 - t_rise), W'(32 * CLK_P));
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * CLK_P);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    check_divider();
    run_stream(1, 1'b0);
    run_stream(23, 1'b0);
    run_stream(47, 1'b1);
    run_stream(71, 1'b0);
    done = 1'b1;
    report();
  end
endmodule